// File: doc/BRIEF.md
# Standby Suspend Sequencer

This block carries a processor system into and out of its low-power standby states once software has chosen one. It supports three modes. Freeze stops the clocks and lowers the supply request to its minimum level, and all logic state stays where it is. Hibernation freezes the I/O and switches the supply off, and no hardware state is saved. Cryo does what Hibernation does, but first shifts the register scan chain out to external storage. On the way back it shifts the chain back in before the clocks restart.

Each step is a phase of one state machine, and the current phase is shown on a status port. A change of supply level holds the sequence until the external converter pulses its acknowledge. In standby the block waits for whichever comes first: a programmable down-counting timer or an interrupt. An interrupt that arrives during the entry steps is held, so the block wakes as soon as entry is complete.

Scan traffic uses two 1-bit valid/ready streams:
- **Save stream (outbound).** The block raises `sv_valid` and holds it, with the data unchanged, until the sink takes the bit with `sv_ready`.
- **Load stream (inbound).** The block raises `ld_ready` only while it is loading the chain, and it takes a bit only when `ld_valid` is also high.
- **Chain movement.** The chain moves exactly one position per accepted bit.

Top module: `standby_seq`

## Requirements
- R1: After reset:
  - `st_phase` is 0 (idle).
  - `clk_stop_req` and `io_freeze` are low.
  - `supply_req` is 2'b11 (nominal).
  - `sv_valid` and `ld_ready` are low.
  - `st_mode` is 0.
  - In idle the three control outputs keep these values.
- R2: A `start` pulse in idle begins a sequence when `mode_sel` is 1 (Freeze), 2 (Hibernation) or 3 (Cryo). Each of the following is ignored, leaving `st_phase` and `st_mode` unchanged:
  - `start` with `mode_sel` = 0;
  - `start` while a sequence is running.
- R3: Freeze visits these phases in order: 1 clock-off, 4 power-down, 5 sleep, 8 clock-on, 6 power-up, 0 idle.
  - `supply_req` is 2'b01 (minimum) from power-down through clock-on.
  - `io_freeze` stays low throughout.
  - The clocks are released before nominal supply is requested again.
- R4: Cryo entry visits these phases in order: 1 clock-off, 2 I/O-freeze, 3 save, 4 power-down, 5 sleep.
  - The clocks stop before the I/O freeze.
  - `supply_req` becomes 2'b00 (off) only while clocks are stopped and I/O is frozen.
- R5: Cryo exit visits these phases in order: 6 power-up (nominal supply), 7 load, 8 clock-on, 9 I/O-release, 0 idle. Clocks restart only after nominal supply is requested, and the I/O is released after that.
- R6: Hibernation follows the Cryo sequence without phases 3 and 7, and moves no scan bits.
- R7: The power-down and power-up phases are left only on the clock edge that samples `supply_ack` high.
- R8: Scan transfer:
  - The save phase sends exactly `scan_len` bits (latched at start), each taken from `chain_tail`.
  - The load phase drives exactly `scan_len` bits from `ld_data` onto `chain_head`.
  - `chain_shift` pulses once per accepted bit.
  - A length of 0 passes through both phases with no transfer.
- R9: Back-pressure:
  - Once raised, `sv_valid` stays high until `sv_ready` takes the bit.
  - `ld_ready` is high only in the load phase.
  - The chain never shifts without a completed handshake.
- R10: With no interrupt, the sleep phase lasts `timeout_val` + 1 cycles. `timeout_val` is latched at start.
- R11: Interrupt wake:
  - `irq` seen during entry makes the sleep phase last 1 cycle.
  - `irq` seen during sleep ends the sleep phase one cycle after it is sampled.
  - `irq` seen in idle has no effect on the next sequence.
- R12: `st_mode` shows the mode code of the last accepted sequence and keeps it after the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a standby sequence |
| mode_sel | input | 2 | 1 Freeze, 2 Hibernation, 3 Cryo |
| timeout_val | input | TMR_W | Wake timer count, latched at start |
| scan_len | input | LEN_W | Number of scan bits, latched at start |
| irq | input | 1 | Wake interrupt |
| supply_ack | input | 1 | Converter reached requested level (pulse) |
| clk_stop_req | output | 1 | Request to stop system clocks |
| io_freeze | output | 1 | Hold I/O drivers frozen |
| supply_req | output | 2 | 11 nominal, 01 minimum, 00 off |
| chain_shift | output | 1 | Shift the register scan chain one place |
| chain_head | output | 1 | Bit entering the scan chain |
| chain_tail | input | 1 | Bit leaving the scan chain |
| sv_valid | output | 1 | Save stream bit valid |
| sv_ready | input | 1 | Save stream sink ready |
| sv_data | output | 1 | Save stream bit |
| ld_valid | input | 1 | Load stream bit valid |
| ld_ready | output | 1 | Load stream accepts a bit |
| ld_data | input | 1 | Load stream bit |
| st_phase | output | 4 | Current phase code |
| st_mode | output | 2 | Mode of the last accepted sequence |

## Verification
Every internal step is visible on `st_phase` and on the three control levels in the same cycle. A wrong transition, or a phase that is skipped or repeated, therefore shows up on the next clock edge. A miscounted scan counter shows up at the stream ports before power is removed, as a missing or extra beat. That error also leaves the chain contents wrong after the load phase. A timer or interrupt-latch fault changes the number of cycles spent in sleep, so the bench counts those cycles exactly for each kind of wake.

// File: rtl/standby_pkg.sv
`timescale 1ns/1ps
package standby_pkg;
  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_FREEZE = 2'd1,
    MODE_HIBER  = 2'd2,
    MODE_CRYO   = 2'd3
  } sb_mode_e;

  typedef enum logic [3:0] {
    PH_IDLE    = 4'd0,
    PH_CLK_OFF = 4'd1,
    PH_IO_FRZ  = 4'd2,
    PH_SAVE    = 4'd3,
    PH_PWR_DN  = 4'd4,
    PH_SLEEP   = 4'd5,
    PH_PWR_UP  = 4'd6,
    PH_LOAD    = 4'd7,
    PH_CLK_ON  = 4'd8,
    PH_IO_REL  = 4'd9
  } sb_phase_e;

  localparam logic [1:0] SUP_NOM = 2'b11;
  localparam logic [1:0] SUP_MIN = 2'b01;
  localparam logic [1:0] SUP_OFF = 2'b00;
endpackage

// File: rtl/sb_wake_timer.sv
`timescale 1ns/1ps
module sb_wake_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sb_scan_count.sv
`timescale 1ns/1ps
module sb_scan_count #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             active,
  input  logic             beat,
  output logic             more,
  output logic             done
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (load) len_q <= len_in;
  end

  // count restarts each time the block enters a scan phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (beat)    cnt_q <= cnt_q + 1'b1;
  end

  assign more = active && (cnt_q < len_q);
  assign done = active && (cnt_q == len_q);
endmodule

// File: rtl/sb_seq_fsm.sv
`timescale 1ns/1ps
module sb_seq_fsm
  import standby_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic [1:0] mode_sel,
  input  logic      irq,
  input  logic      supply_ack,
  input  logic      tmr_expired,
  input  logic      scan_done,
  output sb_phase_e phase,
  output sb_mode_e  mode_q,
  output logic      accept,
  output logic      clk_stop_req,
  output logic      io_freeze,
  output logic [1:0] supply_req
);
  sb_phase_e nxt;
  logic      irq_pend;
  logic      is_frz;
  logic      is_cryo;
  logic      wake;
  logic      sup_low;

  assign is_frz  = (mode_q == MODE_FREEZE);
  assign is_cryo = (mode_q == MODE_CRYO);
  assign wake    = irq_pend || tmr_expired;
  assign accept  = (phase == PH_IDLE) && start && (mode_sel != 2'd0);

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE:    if (accept) nxt = PH_CLK_OFF;
      PH_CLK_OFF: nxt = is_frz ? PH_PWR_DN : PH_IO_FRZ;
      PH_IO_FRZ:  nxt = is_cryo ? PH_SAVE : PH_PWR_DN;
      PH_SAVE:    if (scan_done) nxt = PH_PWR_DN;
      PH_PWR_DN:  if (supply_ack) nxt = PH_SLEEP;
      PH_SLEEP:   if (wake) nxt = is_frz ? PH_CLK_ON : PH_PWR_UP;
      PH_PWR_UP:  if (supply_ack) nxt = is_frz ? PH_IDLE :
                                        (is_cryo ? PH_LOAD : PH_CLK_ON);
      PH_LOAD:    if (scan_done) nxt = PH_CLK_ON;
      PH_CLK_ON:  nxt = is_frz ? PH_PWR_UP : PH_IO_REL;
      PH_IO_REL:  nxt = PH_IDLE;
      default:    nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      mode_q   <= MODE_NONE;
      irq_pend <= 1'b0;
    end else begin
      phase <= nxt;
      if (accept) begin
        mode_q   <= sb_mode_e'(mode_sel);
        irq_pend <= 1'b0;
      end else if (irq && phase != PH_IDLE) begin
        irq_pend <= 1'b1;
      end
    end
  end

  // control levels decoded from the registered phase
  always_comb begin
    clk_stop_req = (phase inside {PH_CLK_OFF, PH_IO_FRZ, PH_SAVE, PH_PWR_DN, PH_SLEEP})
                || (!is_frz && (phase inside {PH_PWR_UP, PH_LOAD}));
    io_freeze    = !is_frz && (phase inside {PH_IO_FRZ, PH_SAVE, PH_PWR_DN, PH_SLEEP,
                                             PH_PWR_UP, PH_LOAD, PH_CLK_ON});
    sup_low      = (phase inside {PH_PWR_DN, PH_SLEEP}) || (is_frz && phase == PH_CLK_ON);
    supply_req   = sup_low ? (is_frz ? SUP_MIN : SUP_OFF) : SUP_NOM;
  end
endmodule

// File: rtl/standby_seq.sv
`timescale 1ns/1ps
module standby_seq
  import standby_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode_sel,
  input  logic [TMR_W-1:0] timeout_val,
  input  logic [LEN_W-1:0] scan_len,
  input  logic             irq,
  input  logic             supply_ack,
  output logic             clk_stop_req,
  output logic             io_freeze,
  output logic [1:0]       supply_req,
  output logic             chain_shift,
  output logic             chain_head,
  input  logic             chain_tail,
  output logic             sv_valid,
  input  logic             sv_ready,
  output logic             sv_data,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic             ld_data,
  output logic [3:0]       st_phase,
  output logic [1:0]       st_mode
);
  sb_phase_e phase;
  sb_mode_e  mode_q;
  logic      accept;
  logic      tmr_expired;
  logic      scan_active;
  logic      scan_beat;
  logic      scan_more;
  logic      scan_done;
  logic      in_save;
  logic      in_load;

  assign in_save     = (phase == PH_SAVE);
  assign in_load     = (phase == PH_LOAD);
  assign scan_active = in_save || in_load;

  sb_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mode_sel     (mode_sel),
    .irq          (irq),
    .supply_ack   (supply_ack),
    .tmr_expired  (tmr_expired),
    .scan_done    (scan_done),
    .phase        (phase),
    .mode_q       (mode_q),
    .accept       (accept),
    .clk_stop_req (clk_stop_req),
    .io_freeze    (io_freeze),
    .supply_req   (supply_req)
  );

  sb_wake_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (timeout_val),
    .run      (phase == PH_SLEEP),
    .expired  (tmr_expired)
  );

  sb_scan_count #(.LEN_W(LEN_W)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .len_in (scan_len),
    .active (scan_active),
    .beat   (scan_beat),
    .more   (scan_more),
    .done   (scan_done)
  );

  // scan streams: one direction per phase
  assign sv_valid    = in_save && scan_more;
  assign sv_data     = chain_tail;
  assign ld_ready    = in_load && scan_more;
  assign scan_beat   = (sv_valid && sv_ready) || (ld_valid && ld_ready);
  assign chain_shift = scan_beat;
  assign chain_head  = in_load ? ld_data : 1'b0;

  assign st_phase = phase;
  assign st_mode  = mode_q;
endmodule

// File: rtl/standby_seq_chk.sv
`timescale 1ns/1ps
module standby_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ack,
  input logic       clk_stop_req,
  input logic       io_freeze,
  input logic [1:0] supply_req,
  input logic       chain_shift,
  input logic       sv_valid,
  input logic       sv_ready,
  input logic       ld_valid,
  input logic       ld_ready,
  input logic [3:0] st_phase,
  input logic [1:0] st_mode
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_phase == 4'd0 |-> (!clk_stop_req && !io_freeze && supply_req == 2'b11));

  p_freeze_keeps_io_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_mode == 2'd1 |-> !io_freeze);

  p_clk_before_io_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_freeze) |-> clk_stop_req);

  p_off_needs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    supply_req == 2'b00 |-> (io_freeze && clk_stop_req));

  p_clk_after_supply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_stop_req) && st_mode != 2'd1) |-> supply_req == 2'b11);

  p_wait_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_phase == 4'd4 && !supply_ack) |=> st_phase == 4'd4);

  p_one_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sv_valid && ld_ready));

  p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_valid && !sv_ready) |=> sv_valid);

  p_shift_on_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_shift |-> ((sv_valid && sv_ready) || (ld_valid && ld_ready)));
endmodule

bind standby_seq standby_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_ack   (supply_ack),
  .clk_stop_req (clk_stop_req),
  .io_freeze    (io_freeze),
  .supply_req   (supply_req),
  .chain_shift  (chain_shift),
  .sv_valid     (sv_valid),
  .sv_ready     (sv_ready),
  .ld_valid     (ld_valid),
  .ld_ready     (ld_ready),
  .st_phase     (st_phase),
  .st_mode      (st_mode)
);

// File: tb/standby_seq_test.sv
`timescale 1ns/1ps
module standby_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [15:0] timeout_val = '0;
  logic [11:0] scan_len = '0;
  logic        irq = 1'b0;
  logic        supply_ack;
  logic        clk_stop_req, io_freeze, chain_shift, chain_head, chain_tail;
  logic [1:0]  supply_req, st_mode;
  logic        sv_valid, sv_ready, sv_data, ld_valid, ld_ready, ld_data;
  logic [3:0]  st_phase;

  always #2 clk = ~clk;

  standby_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .timeout_val(timeout_val), .scan_len(scan_len), .irq(irq),
    .supply_ack(supply_ack), .clk_stop_req(clk_stop_req), .io_freeze(io_freeze),
    .supply_req(supply_req), .chain_shift(chain_shift), .chain_head(chain_head),
    .chain_tail(chain_tail), .sv_valid(sv_valid), .sv_ready(sv_ready),
    .sv_data(sv_data), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_data(ld_data), .st_phase(st_phase), .st_mode(st_mode)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- scoreboard of phase tuples ----------------
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] last_ph = 4'd0;
  int         sleep_cyc, dn_cyc;

  task automatic push_item(logic [3:0] ph, bit cs, bit io, logic [1:0] sup, string tag);
    exp_q.push_back({ph, cs, io, sup});
    tag_q.push_back(tag);
  endtask

  task automatic push_freeze();
    push_item(4'd1, 1, 0, 2'b11, "R3");
    push_item(4'd4, 1, 0, 2'b01, "R3");
    push_item(4'd5, 1, 0, 2'b01, "R3");
    push_item(4'd8, 0, 0, 2'b01, "R3");
    push_item(4'd6, 0, 0, 2'b11, "R3");
    push_item(4'd0, 0, 0, 2'b11, "R3");
  endtask

  task automatic push_deep(bit with_scan);
    string te = with_scan ? "R4" : "R6";
    string tx = with_scan ? "R5" : "R6";
    push_item(4'd1, 1, 0, 2'b11, te);
    push_item(4'd2, 1, 1, 2'b11, te);
    if (with_scan) push_item(4'd3, 1, 1, 2'b11, te);
    push_item(4'd4, 1, 1, 2'b00, te);
    push_item(4'd5, 1, 1, 2'b00, te);
    push_item(4'd6, 1, 1, 2'b11, tx);
    if (with_scan) push_item(4'd7, 1, 1, 2'b11, tx);
    push_item(4'd8, 0, 1, 2'b11, tx);
    push_item(4'd9, 0, 0, 2'b11, tx);
    push_item(4'd0, 0, 0, 2'b11, tx);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (st_phase != last_ph) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2", "unexpected phase", st_phase, last_ph);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({st_phase, clk_stop_req, io_freeze, supply_req} == e, t,
              "phase/clk/io/supply tuple",
              {st_phase, clk_stop_req, io_freeze, supply_req}, e);
        end
        last_ph = st_phase;
      end
      if (st_phase == 4'd5) sleep_cyc++;
      if (st_phase == 4'd4) dn_cyc++;
    end
  end

  // ---------------- converter model ----------------
  int         ack_dly = 3;
  logic [1:0] seen_sup = 2'b11;
  initial begin
    supply_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && supply_req != seen_sup) begin
        seen_sup = supply_req;
        repeat (ack_dly) @(negedge clk);
        supply_ack = 1'b1;
        @(negedge clk);
        supply_ack = 1'b0;
      end
    end
  end

  // ---------------- scan chain and stream partners ----------------
  logic [15:0] chain = '0;
  logic [15:0] chain_init = '0;
  logic        chain_ld = 1'b0;
  logic [15:0] saved = '0;
  int          sv_cnt, ld_cnt, cyc;
  int          bp_seen, bp_err, ldr_err;
  bit          hold_prev;

  assign chain_tail = chain[0];
  always @(posedge clk) begin
    if (chain_ld)         chain <= chain_init;
    else if (chain_shift) chain <= {chain_head, chain[15:1]};
  end

  initial begin
    sv_ready = 1'b0; ld_valid = 1'b0; ld_data = 1'b0; hold_prev = 0;
    forever begin
      @(negedge clk);
      cyc++;
      sv_ready = (cyc % 3) != 1;
      ld_valid = (cyc % 4) != 2;
      ld_data  = (ld_cnt < 16) ? saved[ld_cnt] : 1'b0;
      #1;
      if (hold_prev) begin
        bp_seen++;
        if (!sv_valid) bp_err++;
      end
      hold_prev = sv_valid && !sv_ready;
      if (ld_ready && st_phase != 4'd7) ldr_err++;
      if (sv_valid && sv_ready) begin
        if (sv_cnt < 16) saved[sv_cnt] = sv_data;
        sv_cnt++;
      end
      if (ld_valid && ld_ready) ld_cnt++;
    end
  end

  // ---------------- driver tasks ----------------
  task automatic start_seq(logic [1:0] m, int t, int len);
    sleep_cyc = 0; dn_cyc = 0; sv_cnt = 0; ld_cnt = 0;
    @(negedge clk);
    start = 1'b1; mode_sel = m; timeout_val = 16'(t); scan_len = 12'(len);
    @(negedge clk);
    start = 1'b0; mode_sel = 2'd0;
  endtask

  task automatic wait_idle();
    while (st_phase != 4'd0) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(st_phase == 4'd0, "R1", "reset phase", st_phase, 0);
    chk(!clk_stop_req && !io_freeze, "R1", "reset clk/io", {clk_stop_req, io_freeze}, 0);
    chk(supply_req == 2'b11, "R1", "reset supply", supply_req, 3);
    chk(!sv_valid && !ld_ready, "R1", "reset streams", {sv_valid, ld_ready}, 0);
    chk(st_mode == 2'd0, "R1", "reset mode", st_mode, 0);

    // R2 mode code 0 ignored
    start_seq(2'd0, 5, 0);
    repeat (5) @(negedge clk);
    chk(st_phase == 4'd0, "R2", "mode 0 start ignored", st_phase, 0);
    chk(st_mode == 2'd0, "R2", "mode 0 leaves status", st_mode, 0);

    // R11 interrupt while idle ignored; R3 freeze; R10 timer; R7 ack wait
    @(negedge clk); irq = 1'b1; @(negedge clk); irq = 1'b0;
    ack_dly = 3;
    push_freeze();
    start_seq(2'd1, 10, 0);
    wait_idle();
    chk(sleep_cyc == 11, "R10", "sleep cycles timer 10", sleep_cyc, 11);
    chk(sleep_cyc == 11, "R11", "idle irq had no effect", sleep_cyc, 11);
    chk(dn_cyc == 4, "R7", "power-down cycles ack delay 3", dn_cyc, 4);
    chk(st_mode == 2'd1, "R12", "freeze mode held", st_mode, 1);
    chk(sv_cnt == 0 && ld_cnt == 0, "R8", "freeze moves no scan bits", sv_cnt + ld_cnt, 0);

    // R4 R5 R8 cryo with scan
    @(negedge clk); chain_init = 16'hA5C3; chain_ld = 1'b1;
    @(negedge clk); chain_ld = 1'b0;
    ack_dly = 6;
    push_deep(1'b1);
    start_seq(2'd3, 4, 16);
    wait_idle();
    chk(sv_cnt == 16, "R8", "bits saved", sv_cnt, 16);
    chk(saved == 16'hA5C3, "R8", "saved image", saved, 16'hA5C3);
    chk(ld_cnt == 16, "R8", "bits loaded", ld_cnt, 16);
    chk(chain == 16'hA5C3, "R8", "chain restored", chain, 16'hA5C3);
    chk(dn_cyc == 7, "R7", "power-down cycles ack delay 6", dn_cyc, 7);
    chk(sleep_cyc == 5, "R10", "sleep cycles timer 4", sleep_cyc, 5);
    chk(st_mode == 2'd3, "R12", "cryo mode held", st_mode, 3);
    chk(bp_seen > 0, "R9", "back-pressure exercised", bp_seen, 1);
    chk(bp_err == 0, "R9", "valid dropped under back-pressure", bp_err, 0);

    // R6 hibernation
    ack_dly = 2;
    push_deep(1'b0);
    start_seq(2'd2, 2, 16);
    wait_idle();
    chk(sv_cnt == 0 && ld_cnt == 0, "R6", "hibernation moves no scan bits", sv_cnt + ld_cnt, 0);
    chk(sleep_cyc == 3, "R10", "sleep cycles timer 2", sleep_cyc, 3);
    chk(st_mode == 2'd2, "R12", "hibernation mode held", st_mode, 2);

    // R11 interrupt during entry
    push_deep(1'b0);
    start_seq(2'd2, 1000, 0);
    irq = 1'b1; @(negedge clk); irq = 1'b0;
    wait_idle();
    chk(sleep_cyc == 1, "R11", "entry irq gives 1 sleep cycle", sleep_cyc, 1);

    // R11 interrupt during sleep
    push_freeze();
    start_seq(2'd1, 1000, 0);
    while (st_phase != 4'd5) @(negedge clk);
    repeat (3) @(negedge clk);
    irq = 1'b1; @(negedge clk); irq = 1'b0;
    wait_idle();
    chk(sleep_cyc == 5, "R11", "sleep irq wake latency", sleep_cyc, 5);

    // R2 start while busy ignored; R8 zero length
    push_deep(1'b1);
    start_seq(2'd3, 20, 0);
    while (st_phase != 4'd5) @(negedge clk);
    start = 1'b1; mode_sel = 2'd1;
    @(negedge clk);
    start = 1'b0; mode_sel = 2'd0;
    chk(st_mode == 2'd3, "R2", "busy start leaves mode", st_mode, 3);
    chk(st_phase == 4'd5, "R2", "busy start leaves phase", st_phase, 5);
    wait_idle();
    chk(sv_cnt == 0 && ld_cnt == 0, "R8", "zero length moves nothing", sv_cnt + ld_cnt, 0);
    chk(st_mode == 2'd3, "R12", "mode after ignored start", st_mode, 3);
    chk(ldr_err == 0, "R9", "load ready outside load phase", ldr_err, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule